// File: doc/BRIEF.md
# I2C Master Byte Engine with Register-Armed Bus Conditions

This block is a single-master I2C controller that a processor runs through four small registers. Writing a mode code to the control register only arms an action. Nothing appears on the bus until the next write to the data register. That write issues a START and sends the address, sends or receives one byte, or issues a STOP. After each byte and its acknowledge slot, the engine raises an interrupt request and parks the bus with SCL held low until software asks for the next step.

SCL and SDA are open-drain. The block drives a line low by raising its output-enable (`scl_oe`, `sda_oe`) and reads the SDA wire back on `sda_in`. The SCL rate comes from a fixed divider: every bus phase lasts `CLK_DIV` system clocks. A bit has four phases: low, high, high, low. SDA is sampled at the end of the first high phase. Target clock stretching, arbitration and slave operation are not part of this block.

The engine FSM has these states:
- `ST_IDLE`: bus free, lines released.
- `ST_START_A` (both released), `ST_START_B` (SDA low, SCL high) and `ST_START_C` (both low): the START sequence.
- `ST_BIT`: eight data bits, four phases each.
- `ST_ACK`: the ninth clock.
- `ST_HOLD`: SCL low, waiting for software.
- `ST_STOP_A` (both low), `ST_STOP_B` (SCL released) and `ST_STOP_C` (both released): the STOP sequence.

The transitions are:
- IDLE→START_A on a data write with start armed.
- START_A→START_B→START_C→BIT, one phase each.
- BIT→BIT at the end of each bit, and BIT→ACK after bit 7.
- ACK→HOLD after the ninth clock.
- HOLD→BIT on a data write when no stop is armed.
- HOLD→STOP_A on a data write with stop armed.
- STOP_A→STOP_B→STOP_C→IDLE, one phase each.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both output-enables are 0, the status register (address 0) reads 00h, the data register (address 1) reads 00h and `irq` is 0.
- R2: Writing E0h to the control register while the busy bit is 0 sets the start-armed bit. The next data write then produces a START (SDA falls while SCL is high) and shifts the written byte out MSB first as the address byte, with the direction flag in bit 0. E0h written while busy is ignored.
- R3: Each SCL period lasts 4·CLK_DIV clocks, with SCL released for 2·CLK_DIV of them. SDA changes while SCL is released only inside START and STOP.
- R4: The acknowledge level that the target drives in the ninth clock after a transmitted byte is stored in status bit 4 (1 = NACK).
- R5: Control value AFh sets receive mode (status bit 3). In receive mode each data write, whatever its value, clocks in one byte MSB first. The byte stays readable at address 1 until the next data write.
- R6: Bit 0 of address 2 sets the ninth-clock level during reception: 0 drives SDA low (ACK), 1 leaves it released (NACK).
- R7: Control value C0h sets the stop-armed bit (status bit 2). The next data write in HOLD produces a STOP (SDA rises while SCL is high), then releases both lines and clears busy.
- R8: `irq` and status bit 6 are set when the ninth clock of a byte ends. They stay set until a pulse on `irq_ack` or any write to address 3. A STOP does not set them.
- R9: A data write while a byte or condition is in progress has no effect on the bus and sets the sticky error bit (status bit 5). A write to address 3 clears it.
- R10: A data write while idle with no start armed causes no bus activity.
- R11: Any control value other than E0h, AFh and C0h selects transmit mode. Each data write in HOLD then sends the written byte MSB first.
- R12: The busy bit (status bit 7) rises at the data write that issues a START and stays set until the STOP ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 data, 2 ack control, 3 flag clear |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 status, 1 data, 2 ack control |
| rd_data | output | 8 | Read data (combinational) |
| irq_ack | input | 1 | Interrupt acceptance, clears the request |
| irq | output | 1 | Interrupt request |
| sda_in | input | 1 | SDA wire level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Transmission is swept over all 256 byte values, so every bit position is shown to leave in the right order. The target's acknowledge alternates in a fixed pattern so that a stuck or inverted NACK status bit is caught. Reception is swept over 256 values that a bus-side target model drives; the data written with each dummy write also varies, which separates received bits from leftover written bits. The ninth clock is checked with both ACK and NACK control. Writes that arrive mid-byte, while idle, or with E0h while busy each check that the bus and the START/STOP counts stay untouched.

// File: rtl/i2c_bm_pkg.sv
`timescale 1ns/1ps
package i2c_bm_pkg;

    localparam int REG_W = 8;

    localparam logic [REG_W-1:0] MODE_START = 8'hE0;
    localparam logic [REG_W-1:0] MODE_RECV  = 8'hAF;
    localparam logic [REG_W-1:0] MODE_STOP  = 8'hC0;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_DATA = 2'd1;
    localparam logic [1:0] REG_ACKC = 2'd2;
    localparam logic [1:0] REG_CLR  = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_A,
        ST_START_B,
        ST_START_C,
        ST_BIT,
        ST_ACK,
        ST_HOLD,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C
    } bus_state_e;

endpackage

// File: rtl/i2c_bm_tick.sv
`timescale 1ns/1ps
module i2c_bm_tick #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sync || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = !sync && (cnt == LAST);

    generate
        if (DIV > 1) begin : g_gap_chk
            // R3: phase ticks never arrive back to back when a phase spans several clocks
            a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/i2c_bm_engine.sv
`timescale 1ns/1ps
module i2c_bm_engine
    import i2c_bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_start,
    input  logic             cmd_byte,
    input  logic             cmd_stop,
    input  logic             cmd_rx,
    input  logic [REG_W-1:0] tx_byte,
    input  logic             ack_ctl,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic [REG_W-1:0] shift_q,
    output logic             launch,
    output logic             eng_idle,
    output logic             eng_hold,
    output logic             byte_done,
    output logic             stop_done,
    output logic             ack_sample,
    output logic             byte_was_tx
);

    localparam int BW = $clog2(REG_W);
    localparam logic [BW-1:0] LASTBIT = BW'(REG_W - 1);

    bus_state_e       state;
    logic [1:0]       ph;
    logic [BW-1:0]    bitn;
    logic [REG_W-1:0] shift;
    logic             samp;
    logic             ackbit;
    logic             cur_rx;
    logic             cur_ack;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ph      <= 2'd0;
            bitn    <= '0;
            shift   <= '0;
            samp    <= 1'b1;
            ackbit  <= 1'b1;
            cur_rx  <= 1'b0;
            cur_ack <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_start) begin
                        state  <= ST_START_A;
                        shift  <= tx_byte;
                        cur_rx <= 1'b0;
                    end
                end
                ST_START_A: if (tick) state <= ST_START_B;
                ST_START_B: if (tick) state <= ST_START_C;
                ST_START_C: begin
                    if (tick) begin
                        state <= ST_BIT;
                        ph    <= 2'd0;
                        bitn  <= '0;
                    end
                end
                ST_BIT: begin
                    if (tick) begin
                        ph <= ph + 2'd1;
                        if (ph == 2'd1) samp <= sda_in;
                        if (ph == 2'd3) begin
                            shift <= {shift[REG_W-2:0], samp};
                            if (bitn == LASTBIT) begin
                                state   <= ST_ACK;
                                cur_ack <= ack_ctl;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (tick) begin
                        ph <= ph + 2'd1;
                        if (ph == 2'd1) ackbit <= sda_in;
                        if (ph == 2'd3) state <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (cmd_stop) begin
                        state <= ST_STOP_A;
                    end else if (cmd_byte) begin
                        state  <= ST_BIT;
                        ph     <= 2'd0;
                        bitn   <= '0;
                        cur_rx <= cmd_rx;
                        shift  <= cmd_rx ? '1 : tx_byte;
                    end
                end
                ST_STOP_A: if (tick) state <= ST_STOP_B;
                ST_STOP_B: if (tick) state <= ST_STOP_C;
                ST_STOP_C: if (tick) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // line drivers and event outputs
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_IDLE, ST_START_A: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
            ST_START_B: begin
                scl_oe = 1'b0;
                sda_oe = 1'b1;
            end
            ST_START_C, ST_STOP_A: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            ST_BIT: begin
                scl_oe = (ph == 2'd0) || (ph == 2'd3);
                sda_oe = !cur_rx && !shift[REG_W-1];
            end
            ST_ACK: begin
                scl_oe = (ph == 2'd0) || (ph == 2'd3);
                sda_oe = cur_rx && !cur_ack;
            end
            ST_HOLD: begin
                scl_oe = 1'b1;
                sda_oe = 1'b0;
            end
            ST_STOP_B: begin
                scl_oe = 1'b0;
                sda_oe = 1'b1;
            end
            ST_STOP_C: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end

    assign eng_idle    = (state == ST_IDLE);
    assign eng_hold    = (state == ST_HOLD);
    assign launch      = (eng_idle && cmd_start) || (eng_hold && (cmd_byte || cmd_stop));
    assign byte_done   = (state == ST_ACK) && tick && (ph == 2'd3);
    assign stop_done   = (state == ST_STOP_C) && tick;
    assign ack_sample  = ackbit;
    assign byte_was_tx = !cur_rx;
    assign shift_q     = shift;

    // R3: SDA moves under a released SCL only while forming START or STOP
    a_r3_sda_edge_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
            |-> (state == ST_START_B || state == ST_STOP_C));

    // R8: a finished byte always parks the bus in the hold state
    a_r8_done_then_hold: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> eng_hold);

    // R7: after a stop both lines are released
    a_r7_released_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |=> (!scl_oe && !sda_oe && eng_idle));

endmodule

// File: rtl/i2c_bm_regs.sv
`timescale 1ns/1ps
module i2c_bm_regs
    import i2c_bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             irq_ack,
    input  logic             eng_idle,
    input  logic             eng_hold,
    input  logic             byte_done,
    input  logic             stop_done,
    input  logic             ack_sample,
    input  logic             byte_was_tx,
    output logic             cmd_start,
    output logic             cmd_byte,
    output logic             cmd_stop,
    output logic             cmd_rx,
    output logic             ack_ctl,
    output logic             busy,
    output logic             irq,
    output logic             err,
    output logic             nack,
    output logic             rx_mode,
    output logic             start_armed,
    output logic             stop_armed
);

    logic ctrl_wr, data_wr, ackc_wr, clr_wr, late_wr;

    always_comb begin
        ctrl_wr   = wr_en && (wr_addr == REG_CTRL);
        data_wr   = wr_en && (wr_addr == REG_DATA);
        ackc_wr   = wr_en && (wr_addr == REG_ACKC);
        clr_wr    = wr_en && (wr_addr == REG_CLR);
        cmd_start = data_wr && eng_idle && start_armed;
        cmd_stop  = data_wr && eng_hold && stop_armed;
        cmd_byte  = data_wr && eng_hold && !stop_armed;
        cmd_rx    = rx_mode;
        late_wr   = data_wr && !eng_idle && !eng_hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_ctl     <= 1'b0;
            busy        <= 1'b0;
            irq         <= 1'b0;
            err         <= 1'b0;
            nack        <= 1'b0;
            rx_mode     <= 1'b0;
            start_armed <= 1'b0;
            stop_armed  <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                if (wr_data == MODE_START) begin
                    if (!busy) begin
                        start_armed <= 1'b1;
                        stop_armed  <= 1'b0;
                        rx_mode     <= 1'b0;
                    end
                end else if (wr_data == MODE_RECV) begin
                    rx_mode <= 1'b1;
                end else if (wr_data == MODE_STOP) begin
                    stop_armed <= 1'b1;
                end else begin
                    rx_mode <= 1'b0;
                end
            end
            if (ackc_wr) ack_ctl <= wr_data[0];
            if (cmd_start) begin
                start_armed <= 1'b0;
                busy        <= 1'b1;
            end
            if (cmd_stop)  stop_armed <= 1'b0;
            if (stop_done) busy <= 1'b0;
            if (byte_done) begin
                irq <= 1'b1;
            end else if (irq_ack || clr_wr) begin
                irq <= 1'b0;
            end
            if (late_wr) begin
                err <= 1'b1;
            end else if (clr_wr) begin
                err <= 1'b0;
            end
            if (byte_done && byte_was_tx) nack <= ack_sample;
        end
    end

    // R8: the request follows the end of every byte
    a_r8_irq_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> irq);

    // R9: the error flag only drops through the clear register
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_wr) |=> err);

    // R7: busy ends only with a completed stop
    a_r7_busy_ends_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(stop_done));

    // R12: busy begins only with an issued start
    a_r12_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_start));

    // R2: a data write launches at most one bus action
    a_r2_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_start, cmd_byte, cmd_stop}));

endmodule

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int CLK_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             irq_ack,
    output logic             irq,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);

    logic tick, launch;
    logic eng_idle, eng_hold, byte_done, stop_done, ack_sample, byte_was_tx;
    logic cmd_start, cmd_byte, cmd_stop, cmd_rx, ack_ctl;
    logic busy, err, nack, rx_mode, start_armed, stop_armed;
    logic [REG_W-1:0] shift_q;

    i2c_bm_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .sync (launch),
        .tick (tick)
    );

    i2c_bm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .irq_ack    (irq_ack),
        .eng_idle   (eng_idle),
        .eng_hold   (eng_hold),
        .byte_done  (byte_done),
        .stop_done  (stop_done),
        .ack_sample (ack_sample),
        .byte_was_tx(byte_was_tx),
        .cmd_start  (cmd_start),
        .cmd_byte   (cmd_byte),
        .cmd_stop   (cmd_stop),
        .cmd_rx     (cmd_rx),
        .ack_ctl    (ack_ctl),
        .busy       (busy),
        .irq        (irq),
        .err        (err),
        .nack       (nack),
        .rx_mode    (rx_mode),
        .start_armed(start_armed),
        .stop_armed (stop_armed)
    );

    i2c_bm_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmd_start  (cmd_start),
        .cmd_byte   (cmd_byte),
        .cmd_stop   (cmd_stop),
        .cmd_rx     (cmd_rx),
        .tx_byte    (wr_data),
        .ack_ctl    (ack_ctl),
        .sda_in     (sda_in),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .shift_q    (shift_q),
        .launch     (launch),
        .eng_idle   (eng_idle),
        .eng_hold   (eng_hold),
        .byte_done  (byte_done),
        .stop_done  (stop_done),
        .ack_sample (ack_sample),
        .byte_was_tx(byte_was_tx)
    );

    always_comb begin
        unique case (rd_addr)
            REG_CTRL: rd_data = {busy, irq, err, nack, rx_mode, stop_armed, start_armed,
                                 !eng_idle && !eng_hold};
            REG_DATA: rd_data = shift_q;
            REG_ACKC: rd_data = {{(REG_W-1){1'b0}}, ack_ctl};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;

    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       irq_ack = 1'b0;
    wire  [7:0] rd_data;
    wire        irq, scl_oe, sda_oe;

    logic       slv_drive = 1'b0;
    wire        scl_line = !scl_oe;
    wire        sda_line = !(sda_oe || slv_drive);

    always #2.5 clk = ~clk;

    i2c_byte_master #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_ack(irq_ack), .irq(irq),
        .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int checks = 0;
    int errors = 0;

    // bus-side target model and monitor
    int         starts = 0, stops = 0, bits = 0;
    int         cyc = 0, rise_at = 0, period = 0, high_len = 0;
    logic [7:0] cap = 8'd0;
    logic       ack9 = 1'b0;
    logic       quiet = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       role_rx = 1'b0, ack_low = 1'b1, refresh = 1'b0;
    logic [7:0] slv_byte = 8'd0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic slave_bit();
        int pos;
        pos = bits % 9;
        if (quiet) return 1'b0;
        if (role_rx) return (pos < 8) ? !slv_byte[7-pos] : 1'b0;
        return (pos == 8) ? ack_low : 1'b0;
    endfunction

    always @(scl_line or sda_line or refresh) begin
        if (rst_n) begin
            if (scl_line !== m_scl) begin
                if (scl_line === 1'b1) begin
                    if (bits % 9 < 8) cap = {cap[6:0], sda_line};
                    else begin
                        ack9 = sda_line;
                        if (role_rx && sda_line) quiet = 1'b1;
                    end
                    bits++;
                    period  = cyc - rise_at;
                    rise_at = cyc;
                end else begin
                    high_len  = cyc - rise_at;
                    slv_drive = slave_bit();
                end
            end else if (sda_line !== m_sda && scl_line === 1'b1) begin
                if (sda_line === 1'b0) begin
                    starts++;
                    bits  = 0;
                    quiet = 1'b0;
                end else begin
                    stops++;
                end
            end else if (scl_line === 1'b0) begin
                slv_drive = slave_bit();
            end
        end
        m_scl = scl_line;
        m_sda = sda_line;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_irq(input string tag);
        int n;
        n = 0;
        while (irq !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(irq === 1'b1, tag, irq, 1);
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] s;
        int n;
        n = 0;
        rd(2'd0, s);
        while (s[7] !== 1'b0 && n < 2000) begin
            @(negedge clk);
            rd(2'd0, s);
            n++;
        end
        check(s[7] === 1'b0, tag, s[7], 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] s, d, e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(scl_oe === 1'b0 && sda_oe === 1'b0, "R1 lines", {scl_oe, sda_oe}, 0);
        rd(2'd0, s); check(s === 8'h00, "R1 status", s, 0);
        rd(2'd1, d); check(d === 8'h00, "R1 data", d, 0);
        check(irq === 1'b0, "R1 irq", irq, 0);

        // R10 data write while idle and unarmed
        wr(2'd1, 8'h55);
        repeat (40) @(negedge clk);
        check(starts == 0 && bits == 0, "R10 bus quiet", starts + bits, 0);
        rd(2'd0, s); check(s === 8'h00, "R10 status", s, 0);

        // R2 start and address byte
        wr(2'd0, 8'hE0);
        rd(2'd0, s); check(s[1] === 1'b1, "R2 start armed", s[1], 1);
        role_rx = 1'b0; ack_low = 1'b1;
        wr(2'd1, 8'hA4);
        wait_irq("R8 address irq");
        check(starts == 1, "R2 start count", starts, 1);
        check(cap === 8'hA4, "R2 address byte", cap, 8'hA4);
        rd(2'd0, s);
        check(s[7] === 1'b1, "R12 busy", s[7], 1);
        check(s[4] === 1'b0, "R4 ack latched", s[4], 0);
        check(period == 4 * DIV, "R3 scl period", period, 4 * DIV);
        check(high_len == 2 * DIV, "R3 scl high", high_len, 2 * DIV);
        check(stops == 0, "R3 no stray stop", stops, 0);

        // R8 hold then acceptance clear
        repeat (30) @(negedge clk);
        check(irq === 1'b1, "R8 irq held", irq, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check(irq === 1'b0, "R8 irq_ack clear", irq, 0);

        // R2 start arming ignored while busy
        wr(2'd0, 8'hE0);
        rd(2'd0, s); check(s[1] === 1'b0, "R2 E0 while busy", s[1], 0);

        // R11 transmit mode
        wr(2'd0, 8'h80);
        rd(2'd0, s); check(s[3] === 1'b0, "R11 tx mode", s[3], 0);

        // R9 write during a byte
        wr(2'd1, 8'h5A);
        repeat (10) @(negedge clk);
        wr(2'd1, 8'h00);
        rd(2'd0, s); check(s[5] === 1'b1, "R9 err set", s[5], 1);
        wait_irq("R9 irq");
        check(cap === 8'h5A, "R9 byte intact", cap, 8'h5A);
        repeat (40) @(negedge clk);
        check(bits == 18, "R9 no extra byte", bits, 18);
        rd(2'd0, s); check(s[5] === 1'b1, "R9 err sticky", s[5], 1);
        wr(2'd3, 8'h00);
        rd(2'd0, s); check(s[5] === 1'b0 && s[6] === 1'b0, "R9 clear", s, 0);

        // R11 transmit sweep, R4 acknowledge capture
        for (int v = 0; v < 256; v++) begin
            ack_low = (v % 3) != 0;
            wr(2'd1, 8'(v));
            wait_irq("R11 irq");
            check(cap === 8'(v), "R11 tx byte", cap, v);
            rd(2'd0, s);
            check(s[4] === !ack_low, "R4 nack bit", s[4], !ack_low);
            wr(2'd3, 8'h00);
        end
        check(starts == 1 && stops == 0, "R3 no stray conditions", starts * 16 + stops, 16);

        // R5 receive sweep with ACK, R6
        wr(2'd0, 8'hAF);
        rd(2'd0, s); check(s[3] === 1'b1, "R5 rx mode", s[3], 1);
        wr(2'd2, 8'h00);
        role_rx = 1'b1;
        e = 8'h00;
        for (int v = 0; v < 256; v++) begin
            e = 8'((v * 37 + 11) & 255);
            slv_byte = e;
            refresh = ~refresh;
            wr(2'd1, 8'(v ^ 8'h5C));
            wait_irq("R5 irq");
            rd(2'd1, d);
            check(d === e, "R5 rx byte", d, e);
            check(ack9 === 1'b0, "R6 ack driven", ack9, 0);
            wr(2'd3, 8'h00);
        end
        repeat (50) @(negedge clk);
        rd(2'd1, d); check(d === e, "R5 byte held", d, e);

        // R6 last byte with NACK
        wr(2'd2, 8'h01);
        slv_byte = 8'hC3;
        refresh = ~refresh;
        wr(2'd1, 8'h00);
        wait_irq("R6 irq");
        rd(2'd1, d); check(d === 8'hC3, "R5 last byte", d, 8'hC3);
        check(ack9 === 1'b1, "R6 nack released", ack9, 1);
        wr(2'd3, 8'h00);

        // R7 stop
        wr(2'd0, 8'hC0);
        rd(2'd0, s); check(s[2] === 1'b1, "R7 stop armed", s[2], 1);
        wr(2'd1, 8'h00);
        wait_idle("R7 busy clear");
        check(stops == 1, "R7 stop count", stops, 1);
        check(scl_oe === 1'b0 && sda_oe === 1'b0, "R7 lines released", {scl_oe, sda_oe}, 0);
        check(irq === 1'b0, "R8 no irq on stop", irq, 0);
        rd(2'd0, s); check(s[0] === 1'b0 && s[7] === 1'b0, "R12 idle status", s, 0);

        // R2 second transaction, R4 NACK from target
        role_rx = 1'b0; ack_low = 1'b0;
        wr(2'd0, 8'hE0);
        rd(2'd0, s); check(s[1] === 1'b1, "R2 rearm", s[1], 1);
        wr(2'd1, 8'hA5);
        wait_irq("R2 irq");
        check(starts == 2, "R2 second start", starts, 2);
        check(cap === 8'hA5, "R2 read address", cap, 8'hA5);
        rd(2'd0, s); check(s[4] === 1'b1, "R4 nack seen", s[4], 1);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'hC0);
        wr(2'd1, 8'h00);
        wait_idle("R7 second stop");
        check(stops == 2, "R7 second stop count", stops, 2);

        // R10 again after stop
        wr(2'd1, 8'h77);
        repeat (40) @(negedge clk);
        check(starts == 2 && scl_oe === 1'b0, "R10 idle write", starts, 2);

        finish_run();
    end

endmodule